// File: doc/BRIEF.md
# Row-Sum Projector for Tagged Token Streams

This block takes one image as a stream of tagged tokens and returns its horizontal projection: one value per image row, equal to the sum of that row's pixels. Every input token carries a 2-bit tag that marks it as a pixel value, an opening bracket or a closing bracket. A frame is an opening bracket, then any number of rows, then a closing bracket. Each row is itself an opening bracket, its pixels, then a closing bracket. The block pulls tokens from an upstream FIFO through its empty flag and read strobe. It pushes tokens to a downstream FIFO through its full flag and write strobe.

The output keeps the same bracket structure one level down. The block writes an opening bracket when a frame begins. It writes one data token per row when that row closes, carrying the row's sum. It writes a closing bracket when the frame ends. A downstream actor therefore sees a bracketed list of row sums. It can threshold that list or search it without any side-band framing signals.

Each token is consumed with a one-cycle read pulse and is followed by one idle cycle, so the block accepts at most one token every two clock cycles. The accumulator width is a parameter, so long rows can be summed without wrap-around.

Top module: `rowsum_projector`

## Requirements
- R1: While reset is held, and on the first cycle after it, `in_rd` and `out_wr` are both 0, and the block waits for a frame opening.
- R2: When no frame is open, an opening token (tag 01) opens a frame and writes one output token with tag 01 and a zero payload.
- R3: Inside a frame, an opening token starts a row and clears the row sum. Each data token (tag 00) in the row adds its 8-bit value to the sum. The row's closing token (tag 10) writes one output token with tag 00 that carries the sum.
- R4: Inside a frame with no row open, a closing token (tag 10) writes one output token with tag 10 and a zero payload and closes the frame.
- R5: `in_rd` is high for single cycles only, with at least one low cycle between pulses, and never pulses unless `in_empty` was low in the cycle before.
- R6: A token that does not fit the current nesting level is consumed and produces no output. This covers data outside a row, an opening token inside a row, a closing token with no frame open, and the reserved tag 11. The nesting level and the row sum are left unchanged.
- R7: A token that needs an output write is neither consumed nor acted on while `out_full` is high. Data tokens inside a row are still consumed while `out_full` is high.
- R8: The row sum wraps modulo 2^SUM_W (65536 by default).
- R9: Every `out_wr` pulse falls in the same cycle as the `in_rd` pulse that pops the token which caused it.
- R10: A row with no data tokens produces a sum of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_empty | input | 1 | Upstream FIFO has no token |
| in_tok | input | PIX_W+2 | Head token of the upstream FIFO: tag in the top two bits, pixel value below |
| in_rd | output | 1 | Pop strobe for the upstream FIFO |
| out_full | input | 1 | Downstream FIFO cannot accept a token |
| out_tok | output | SUM_W+2 | Output token: tag in the top two bits, payload below |
| out_wr | output | 1 | Push strobe for the downstream FIFO |

## Verification
Some behaviour is checked by assertions on every cycle:
- the handshake rules: isolated read pulses, no pop from an empty FIFO, no write into a full one, and each write paired with a pop;
- that the reserved tag never reaches the output;
- the quiet state after reset.

The rest needs the bench's scenarios, which compare every output token with a behavioural reference model:
- that row sums are correct, including wrap-around and empty rows;
- that misplaced delimiters and stray pixels leave the nesting level and the sum untouched;
- that a stalled row-close is held until the downstream FIFO drains, while pixels still flow in.

// File: rtl/rsp_pkg.sv
// Package: shared tag codes, nesting levels and per-token actions for the
// row-sum projector. Assumes a 2-bit tag at the top of every token.
package rsp_pkg;

    typedef enum logic [1:0] {
        TAG_DATA  = 2'b00,
        TAG_OPEN  = 2'b01,
        TAG_CLOSE = 2'b10,
        TAG_RSVD  = 2'b11
    } tag_e;

    typedef enum logic [1:0] {
        LVL_IDLE  = 2'b00,
        LVL_FRAME = 2'b01,
        LVL_ROW   = 2'b10
    } lvl_e;

    typedef enum logic [2:0] {
        ACT_DROP        = 3'd0,
        ACT_OPEN_FRAME  = 3'd1,
        ACT_OPEN_ROW    = 3'd2,
        ACT_ADD         = 3'd3,
        ACT_CLOSE_ROW   = 3'd4,
        ACT_CLOSE_FRAME = 3'd5
    } act_e;

endpackage

// File: rtl/rsp_classify.sv
// Module: rsp_classify
// Maps the head token's tag and the current nesting level to an action,
// the next level and whether an output write is needed. Purely
// combinational. Anything out of place maps to a drop that keeps the level.
module rsp_classify
    import rsp_pkg::*;
(
    input  tag_e  tag,
    input  lvl_e  lvl,
    output act_e  act,
    output lvl_e  lvl_nxt,
    output logic  needs_out
);

    // Decode the action from the level and the tag
    always_comb begin
        act     = ACT_DROP;
        lvl_nxt = lvl;
        unique case (lvl)
            LVL_IDLE: begin
                if (tag == TAG_OPEN) begin
                    act     = ACT_OPEN_FRAME;
                    lvl_nxt = LVL_FRAME;
                end
            end
            LVL_FRAME: begin
                if (tag == TAG_OPEN) begin
                    act     = ACT_OPEN_ROW;
                    lvl_nxt = LVL_ROW;
                end else if (tag == TAG_CLOSE) begin
                    act     = ACT_CLOSE_FRAME;
                    lvl_nxt = LVL_IDLE;
                end
            end
            LVL_ROW: begin
                if (tag == TAG_DATA) begin
                    act = ACT_ADD;
                end else if (tag == TAG_CLOSE) begin
                    act     = ACT_CLOSE_ROW;
                    lvl_nxt = LVL_FRAME;
                end
            end
            default: begin
                act     = ACT_DROP;
                lvl_nxt = LVL_IDLE;
            end
        endcase
    end

    // Only frame open/close and row close write a token downstream
    always_comb begin
        needs_out = (act == ACT_OPEN_FRAME) || (act == ACT_CLOSE_FRAME) ||
                    (act == ACT_CLOSE_ROW);
    end

endmodule

// File: rtl/rsp_accum.sv
// Module: rsp_accum
// Row-sum register. Cleared when a row opens, adds one pixel per accepted
// data token and wraps modulo 2^SUM_W. Assumes SUM_W >= PIX_W.
module rsp_accum #(
    parameter int PIX_W = 8,
    parameter int SUM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add,
    input  logic [PIX_W-1:0] pix,
    output logic [SUM_W-1:0] sum
);

    localparam int PAD_W = SUM_W - PIX_W;

    logic [SUM_W-1:0] pix_ext;

    // Zero-extend the pixel to the accumulator width
    always_comb begin
        pix_ext = {{PAD_W{1'b0}}, pix};
    end

    // Hold, clear or accumulate the running row sum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum <= '0;
        end else if (clr) begin
            sum <= '0;
        end else if (add) begin
            sum <= sum + pix_ext;
        end
    end

endmodule

// File: rtl/rsp_emit.sv
// Module: rsp_emit
// Output token register. Builds the token for a frame open, a row close or
// a frame close and raises the write strobe for exactly one cycle. Assumes
// the caller fires only when the downstream FIFO has room.
module rsp_emit
    import rsp_pkg::*;
#(
    parameter int SUM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  act_e             act,
    input  logic [SUM_W-1:0] sum,
    output logic [SUM_W+1:0] out_tok,
    output logic             out_wr
);

    logic [SUM_W+1:0] tok_nxt;

    // Select the tag and payload for the action being written
    always_comb begin
        unique case (act)
            ACT_OPEN_FRAME:  tok_nxt = {TAG_OPEN,  {SUM_W{1'b0}}};
            ACT_CLOSE_FRAME: tok_nxt = {TAG_CLOSE, {SUM_W{1'b0}}};
            ACT_CLOSE_ROW:   tok_nxt = {TAG_DATA,  sum};
            default:         tok_nxt = {TAG_DATA,  {SUM_W{1'b0}}};
        endcase
    end

    // Register the token and pulse the write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_tok <= '0;
            out_wr  <= 1'b0;
        end else begin
            out_wr <= fire;
            if (fire) begin
                out_tok <= tok_nxt;
            end
        end
    end

endmodule

// File: rtl/rowsum_projector.sv
// Module: rowsum_projector (top)
// Streams one frame of bracketed rows in and writes a bracketed list of row
// sums out. Every accepted token gets a one-cycle pop strobe followed by one
// idle cycle before the next head token is looked at. Assumes the upstream
// FIFO presents its head token on in_tok whenever in_empty is low.
module rowsum_projector
    import rsp_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int SUM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_empty,
    input  logic [PIX_W+1:0] in_tok,
    output logic             in_rd,
    input  logic             out_full,
    output logic [SUM_W+1:0] out_tok,
    output logic             out_wr
);

    localparam int TOK_W = PIX_W + 2;

    tag_e       head_tag;
    logic [PIX_W-1:0] head_pix;
    lvl_e       lvl_q;
    lvl_e       lvl_nxt;
    act_e       act;
    logic       needs_out;
    logic       look;
    logic       take;
    logic [SUM_W-1:0] row_sum;

    // Split the head token into tag and pixel fields
    always_comb begin
        head_tag = tag_e'(in_tok[TOK_W-1 -: 2]);
        head_pix = in_tok[PIX_W-1:0];
    end

    rsp_classify u_classify (
        .tag       (head_tag),
        .lvl       (lvl_q),
        .act       (act),
        .lvl_nxt   (lvl_nxt),
        .needs_out (needs_out)
    );

    // Look at the head only outside the pop cycle; stall writes when full
    always_comb begin
        look = !in_empty && !in_rd;
        take = look && !(needs_out && out_full);
    end

    // Pop strobe and nesting level, both advanced only on an accepted token
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_rd <= 1'b0;
            lvl_q <= LVL_IDLE;
        end else begin
            in_rd <= take;
            if (take) begin
                lvl_q <= lvl_nxt;
            end
        end
    end

    rsp_accum #(
        .PIX_W (PIX_W),
        .SUM_W (SUM_W)
    ) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (take && (act == ACT_OPEN_ROW)),
        .add   (take && (act == ACT_ADD)),
        .pix   (head_pix),
        .sum   (row_sum)
    );

    rsp_emit #(
        .SUM_W (SUM_W)
    ) u_emit (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (take && needs_out),
        .act     (act),
        .sum     (row_sum),
        .out_tok (out_tok),
        .out_wr  (out_wr)
    );

endmodule

// File: rtl/rsp_checker.sv
// Module: rsp_checker
// Handshake and output-encoding properties of rowsum_projector, attached to
// every instance by the bind below. Observes top-level ports only.
module rsp_checker #(
    parameter int SUM_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_empty,
    input logic             in_rd,
    input logic             out_full,
    input logic [SUM_W+1:0] out_tok,
    input logic             out_wr
);

    // R1: strobes are quiet on the cycle after a reset edge
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!in_rd && !out_wr));

    // R5: a pop pulse is always followed by a low cycle
    a_r5_isolated_pop: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd |=> !in_rd);

    // R5: a pop only follows a cycle with a token present
    a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd |-> $past(!in_empty));

    // R7: never write into a FIFO that reported full
    a_r7_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |-> $past(!out_full));

    // R9: each write coincides with the pop of its token
    a_r9_write_with_pop: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |-> in_rd);

    // R6: the reserved tag never appears downstream
    a_r6_no_reserved_out: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |-> (out_tok[SUM_W+1 -: 2] != 2'b11));

endmodule

bind rowsum_projector rsp_checker #(
    .SUM_W (SUM_W)
) u_rsp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_empty (in_empty),
    .in_rd    (in_rd),
    .out_full (out_full),
    .out_tok  (out_tok),
    .out_wr   (out_wr)
);

// File: tb/tb_rowsum_projector.sv
// Bench for rowsum_projector: a queue stands in for the upstream FIFO, a
// behavioural model predicts every output token, and the ports are compared
// on every falling edge.
module tb_rowsum_projector;

    localparam int PIX_W = 8;
    localparam int SUM_W = 16;
    localparam int TW    = PIX_W + 2;
    localparam int OW    = SUM_W + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_empty = 1'b1;
    logic [TW-1:0] in_tok = '0;
    logic out_full = 1'b0;
    logic in_rd;
    logic out_wr;
    logic [OW-1:0] out_tok;

    logic [TW-1:0] inq[$];
    logic [OW-1:0] expq[$];
    int total = 0;
    int bad = 0;
    int wr_cnt = 0;
    int last_sum = -1;
    int m_lvl = 0;
    int m_acc = 0;
    logic prev_rd = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rowsum_projector #(.PIX_W(PIX_W), .SUM_W(SUM_W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_empty (in_empty),
        .in_tok   (in_tok),
        .in_rd    (in_rd),
        .out_full (out_full),
        .out_tok  (out_tok),
        .out_wr   (out_wr)
    );

    task automatic chk(input string req, input bit ok, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model: nesting level 0 idle, 1 frame, 2 row
    task automatic push(input logic [1:0] tg, input int v);
        logic [TW-1:0] t;
        t = {tg, PIX_W'(v)};
        case (m_lvl)
            0: if (tg == 2'b01) begin
                   expq.push_back({2'b01, SUM_W'(0)}); m_lvl = 1;
               end
            1: if (tg == 2'b01) begin
                   m_acc = 0; m_lvl = 2;
               end else if (tg == 2'b10) begin
                   expq.push_back({2'b10, SUM_W'(0)}); m_lvl = 0;
               end
            default: if (tg == 2'b00) begin
                   m_acc = (m_acc + (v % (1 << PIX_W))) % (1 << SUM_W);
               end else if (tg == 2'b10) begin
                   expq.push_back({2'b00, SUM_W'(m_acc)}); m_lvl = 1;
               end
        endcase
        inq.push_back(t);
    endtask

    task automatic drain();
        for (int i = 0; i < 5000 && (inq.size() != 0 || expq.size() != 0); i++)
            @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R3", inq.size() == 0 && expq.size() == 0, expq.size(), 0);
    endtask

    function automatic string req_of(input logic [1:0] tg);
        if (tg == 2'b01) return "R2";
        if (tg == 2'b10) return "R4";
        return "R3";
    endfunction

    // Per-cycle comparison of ports with the model, and the upstream FIFO
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5", !(in_rd && prev_rd), in_rd, 0);
            chk("R5", !(in_rd && inq.size() == 0), inq.size(), 1);
            chk("R9", !(out_wr && !in_rd), in_rd, 1);
            if (out_wr) begin
                wr_cnt++;
                if (expq.size() == 0) begin
                    chk("R6", 1'b0, out_tok, 0);
                end else begin
                    logic [OW-1:0] e;
                    e = expq.pop_front();
                    chk(req_of(e[OW-1 -: 2]), out_tok == e, out_tok, e);
                    if (out_tok[OW-1 -: 2] == 2'b00) last_sum = int'(out_tok[SUM_W-1:0]);
                end
            end
            if (in_rd && inq.size() > 0) void'(inq.pop_front());
        end
        prev_rd = in_rd;
        in_empty = (inq.size() == 0);
        in_tok = (inq.size() == 0) ? '0 : inq[0];
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk("watchdog", 1'b0, 0, 1);
        finish_run();
    end

    initial begin
        int w0;
        repeat (3) @(negedge clk);
        chk("R1", in_rd == 1'b0, in_rd, 0);
        chk("R1", out_wr == 1'b0, out_wr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", in_rd == 1'b0 && out_wr == 1'b0, {in_rd, out_wr}, 0);

        // R6: stray data, stray close and reserved tag with no frame open
        w0 = wr_cnt;
        push(2'b00, 9); push(2'b10, 0); push(2'b11, 3);
        drain();
        chk("R6", wr_cnt == w0, wr_cnt, w0);

        // R2 R3 R4: frame with several rows and misplaced tokens inside
        push(2'b01, 0);
        push(2'b01, 0); push(2'b00, 10); push(2'b00, 20); push(2'b00, 30); push(2'b10, 0);
        push(2'b00, 77);
        push(2'b01, 0); push(2'b00, 255); push(2'b01, 0); push(2'b00, 1); push(2'b11, 5);
        push(2'b00, 128); push(2'b10, 0);
        push(2'b01, 0); push(2'b00, 200); push(2'b10, 0);
        push(2'b10, 0);
        drain();
        chk("R6", last_sum == 200, last_sum, 200);

        // R7: row close stalls while full, pixels still flow
        push(2'b01, 0); push(2'b01, 0);
        drain();
        w0 = wr_cnt;
        out_full = 1'b1;
        push(2'b00, 5); push(2'b00, 6); push(2'b10, 0);
        repeat (20) @(negedge clk);
        chk("R7", inq.size() == 1, inq.size(), 1);
        chk("R7", wr_cnt == w0, wr_cnt, w0);
        out_full = 1'b0;
        drain();
        chk("R7", last_sum == 11, last_sum, 11);

        // R8: 300 pixels of 255 wrap to 76500 mod 65536
        push(2'b01, 0);
        for (int i = 0; i < 300; i++) push(2'b00, 255);
        push(2'b10, 0);
        drain();
        chk("R8", last_sum == 10964, last_sum, 10964);

        // R10: empty row after non-zero sums
        push(2'b01, 0); push(2'b10, 0); push(2'b10, 0);
        drain();
        chk("R10", last_sum == 0, last_sum, 0);

        // back-to-back frames
        push(2'b01, 0); push(2'b01, 0); push(2'b00, 3); push(2'b10, 0); push(2'b10, 0);
        push(2'b01, 0); push(2'b01, 0); push(2'b00, 4); push(2'b00, 4); push(2'b10, 0);
        push(2'b10, 0);
        drain();
        chk("R3", last_sum == 8, last_sum, 8);

        finish_run();
    end

endmodule